// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block connects a clocked host to a 1M x 16 pseudo-static RAM that has only asynchronous control pins. The host offers one request at a time: a 20-bit word address, a 16-bit write word, two byte-lane enables and a read/write flag, with a valid/ready handshake. The block turns each request into a chip-enable-framed memory cycle on the device pins: address, active-low chip enable, a chip-select that stays high, output enable, write strobe, and one active-low strobe per byte lane. It also drives a split data bus (output value, per-lane drive enable, input value) for an external tri-state pad.

The lengths of the memory cycles are set in nanoseconds through parameters. They are turned into clock counts, rounded up, for the configured clock period. A read holds the device selected for the longer of the cycle time, the address access time and the output-enable access time. A write holds the write strobe low for the longest of the cycle time, the pulse width and the data setup time. After a read, the bus is left undriven for the device's output turn-off time. After a write, chip enable stays high for one cycle before the next request is accepted. A request with no byte lane enabled never touches the memory pins.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the controller sits in the idle state: req_ready is 1, rsp_valid is 0, mem_ce1_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are 1, and mem_dq_oe is 0.
- R2: mem_ce2 is 1 in every cycle.
- R3: An accepted read with req_be nonzero drives mem_ce1_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles. RD_CYC is the largest of ceil(T_RC_NS/CLK_NS), ceil(T_AA_NS/CLK_NS) and ceil(T_OE_NS/CLK_NS). During these cycles mem_addr holds the request address, mem_lb_n = !req_be[0] (bits 7:0), mem_ub_n = !req_be[1] (bits 15:8), and mem_dq_oe is 0.
- R4: The read data are sampled from mem_dq_in at the last clock edge of the read window. rsp_valid is 1 for the single cycle that follows. In that cycle rsp_data holds the sampled lanes, and any lane not enabled reads as zero.
- R5: An accepted write with req_be nonzero drives mem_ce1_n=0, mem_we_n=0 and mem_oe_n=1 for exactly WR_CYC cycles. WR_CYC is the largest of ceil(T_WC_NS/CLK_NS), ceil(T_WP_NS/CLK_NS) and ceil(T_DW_NS/CLK_NS). During these cycles mem_dq_oe equals req_be, mem_dq_out equals req_wdata on the enabled lanes, and the address and lane strobes follow the rules of R3.
- R6: After a read window, all control pins are high and mem_dq_oe is 0 for HZ_CYC = ceil(T_HZ_NS/CLK_NS) cycles before req_ready returns to 1.
- R7: After a write window, the control pins are high for exactly one cycle before req_ready returns to 1.
- R8: req_ready is 1 only while no memory cycle is in progress. A request is accepted only on a clock edge where req_valid and req_ready are both 1.
- R9: A request with req_be=0 produces no memory cycle, and req_ready stays 1. A write of this kind changes nothing. A read of this kind gives rsp_valid in the next cycle with rsp_data=0.
- R10: mem_we_n and mem_oe_n are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_be | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip select, held high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Low-lane strobe, active low |
| mem_ub_n | output | 1 | High-lane strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 2 | Per-lane drive enable for the pad |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Two events can share a cycle. The response pulse of a read with no lanes enabled lands in the same cycle in which the controller is idle and can take the next request. The bench drives a zero-lane read and then, with no gap, a word read of a written address. A per-cycle reference model, built from queued pin expectations, then checks three things in that shared cycle: rsp_valid with zero data, req_ready high, and the new read window starting on the following edge. Write-then-read sequences also check that the lane drive enables fall before output enable rises, and that data written through partial-lane writes merge correctly.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_TURN,
    ST_GAP
  } acc_state_e;

  // nanoseconds to whole clocks, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psram_phase_timer.sv
`timescale 1ns/1ps
module psram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_lane_io.sv
`timescale 1ns/1ps
module psram_lane_io #(
  parameter int LANES = 2,
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic [DW-1:0]    wr_data_in,
  input  logic             drive_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic             cap_en,
  input  logic [LANES-1:0] cap_mask,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] dq_oe,
  output logic [DW-1:0]    rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] wbyte_q;
    logic [7:0] rbyte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wbyte_q <= '0;
      else if (wr_load) wbyte_q <= wr_data_in[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rbyte_q <= '0;
      else if (cap_en) rbyte_q <= cap_mask[g] ? dq_in[8*g +: 8] : 8'h00;
    end

    assign dq_out[8*g +: 8] = wbyte_q;
    assign rd_data[8*g +: 8] = rbyte_q;
    assign dq_oe[g] = drive_en & lane_sel[g];

    // R4: a lane left out of the capture mask returns zero
    p_masked_lane_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !cap_mask[g]) |=> (rd_data[8*g +: 8] == 8'h00));
  end

endmodule

// File: rtl/psram_async_ctrl.sv
`timescale 1ns/1ps
module psram_async_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int AW      = 20,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [15:0]   mem_dq_out,
  output logic [1:0]    mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  localparam int RD_CYC  = max3(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS),
                                ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int WR_CYC  = max3(ns_to_cyc(T_WC_NS, CLK_NS), ns_to_cyc(T_WP_NS, CLK_NS),
                                ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = max3(RD_CYC, WR_CYC, HZ_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int RUN_W   = CNT_W + 1;

  acc_state_e      st_q, st_d;
  logic [AW-1:0]   addr_q;
  logic [1:0]      be_q;
  logic            rsp_valid_q, rsp_valid_d;
  logic            accept;
  logic            tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic            tmr_done;
  logic            cap_en;
  logic [1:0]      cap_mask;
  logic            busy_sel;

  // next-state logic
  always_comb begin
    st_d        = st_q;
    accept      = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    cap_en      = 1'b0;
    rsp_valid_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_be == 2'b00) begin
            if (!req_wr) begin
              cap_en      = 1'b1;
              rsp_valid_d = 1'b1;
            end
          end else if (req_wr) begin
            st_d     = ST_WRITE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WR_CYC - 1);
          end else begin
            st_d     = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          cap_en      = 1'b1;
          rsp_valid_d = 1'b1;
          st_d        = ST_TURN;
          tmr_load    = 1'b1;
          tmr_val     = CNT_W'(HZ_CYC - 1);
        end
      end
      ST_WRITE: if (tmr_done) st_d = ST_GAP;
      ST_TURN:  if (tmr_done) st_d = ST_IDLE;
      ST_GAP:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      be_q   <= req_be;
    end
  end

  psram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign cap_mask = (st_q == ST_IDLE) ? req_be : be_q;

  psram_lane_io #(.LANES(2)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_load    (accept & req_wr),
    .wr_data_in (req_wdata),
    .drive_en   (st_q == ST_WRITE),
    .lane_sel   (be_q),
    .cap_en     (cap_en),
    .cap_mask   (cap_mask),
    .dq_in      (mem_dq_in),
    .dq_out     (mem_dq_out),
    .dq_oe      (mem_dq_oe),
    .rd_data    (rsp_data)
  );

  // pin decode from state
  assign busy_sel  = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign mem_addr  = addr_q;
  assign mem_ce1_n = !busy_sel;
  assign mem_ce2   = 1'b1;
  assign mem_oe_n  = !(st_q == ST_READ);
  assign mem_we_n  = !(st_q == ST_WRITE);
  assign mem_lb_n  = !(busy_sel && be_q[0]);
  assign mem_ub_n  = !(busy_sel && be_q[1]);

  // window length monitors
  logic [RUN_W-1:0] rd_run_q, wr_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run_q <= '0;
      wr_run_q <= '0;
    end else begin
      rd_run_q <= mem_oe_n ? '0 : rd_run_q + 1'b1;
      wr_run_q <= mem_we_n ? '0 : wr_run_q + 1'b1;
    end
  end

  p_ce2_high_r2: assert property (@(posedge clk) disable iff (!rst_n) mem_ce2);
  p_read_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (rd_run_q == RUN_W'(RD_CYC)));
  p_write_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wr_run_q == RUN_W'(WR_CYC)));
  p_no_drive_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != 2'b00) |-> mem_oe_n);
  p_ready_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && mem_dq_oe == 2'b00));
  p_we_oe_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

endmodule

// File: tb/psram_async_ctrl_tb.sv
`timescale 1ns/1ps
module psram_async_ctrl_tb_top;

  localparam int CLK_NS = 8;
  localparam int RD = 9;   // max(ceil(70/8), ceil(70/8), ceil(35/8))
  localparam int WR = 9;   // max(ceil(70/8), ceil(50/8), ceil(30/8))
  localparam int HZ = 4;   // ceil(25/8)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_wr = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [19:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic [1:0]  mem_dq_oe;
  logic [15:0] mem_dq_in = 16'hFFFF;

  always #4 clk = ~clk;

  psram_async_ctrl #(.CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- memory device model ----------------
  logic [15:0] dev_mem [int];

  always @(negedge clk) begin
    logic [15:0] w;
    w = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 16'h0000;
    if (!mem_ce1_n && !mem_we_n) begin
      if (!mem_lb_n && mem_dq_oe[0]) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n && mem_dq_oe[1]) w[15:8] = mem_dq_out[15:8];
      dev_mem[int'(mem_addr)] = w;
    end
    if (!mem_ce1_n && !mem_oe_n && mem_we_n) begin
      mem_dq_in[7:0]  <= mem_lb_n ? 8'hA5 : w[7:0];
      mem_dq_in[15:8] <= mem_ub_n ? 8'h5A : w[15:8];
    end else begin
      mem_dq_in <= 16'hFFFF;
    end
  end

  // ---------------- reference model ----------------
  typedef struct {
    bit ce, oe, we, lb, ub;
    bit [1:0] doe;
    bit rdy, rv;
    logic [19:0] a;
    logic [15:0] d;
    logic [15:0] rd;
    string tag;
  } exp_t;

  exp_t q[$];
  logic [15:0] ref_mem [int];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic exp_t idle_exp();
    exp_t e;
    e.ce = 1; e.oe = 1; e.we = 1; e.lb = 1; e.ub = 1; e.doe = 0;
    e.rdy = 1; e.rv = 0; e.a = '0; e.d = '0; e.rd = '0; e.tag = "R8";
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, expv);
    end
  endtask

  always @(posedge clk) begin
    exp_t e;
    logic [9:0] act_v, exp_v;
    #2;
    if (rst_n && !finished) begin
      e = (q.size() > 0) ? q.pop_front() : idle_exp();
      act_v = {mem_ce2, mem_ce1_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n,
               mem_dq_oe, req_ready, rsp_valid};
      exp_v = {1'b1, e.ce, e.oe, e.we, e.lb, e.ub, e.doe, e.rdy, e.rv};
      check(act_v == exp_v, {e.tag, " R2 R10"}, "control pins", 32'(act_v), 32'(exp_v));
      if (!e.ce)
        check(mem_addr == e.a, e.tag, "mem_addr", 32'(mem_addr), 32'(e.a));
      if (e.doe[0])
        check(mem_dq_out[7:0] == e.d[7:0], "R5", "dq_out low", 32'(mem_dq_out[7:0]), 32'(e.d[7:0]));
      if (e.doe[1])
        check(mem_dq_out[15:8] == e.d[15:8], "R5", "dq_out high", 32'(mem_dq_out[15:8]), 32'(e.d[15:8]));
      if (e.rv)
        check(rsp_data == e.rd, "R4 R9", "rsp_data", 32'(rsp_data), 32'(e.rd));
    end
  end

  function automatic logic [15:0] ref_rd(input logic [19:0] a, input logic [1:0] be);
    logic [15:0] w;
    w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  // call at a negedge with the controller idle
  task automatic issue(input bit wr, input logic [19:0] a, input logic [1:0] be,
                       input logic [15:0] wd);
    exp_t e;
    logic [15:0] w;
    req_valid = 1; req_wr = wr; req_addr = a; req_be = be; req_wdata = wd;
    if (be == 2'b00) begin
      if (!wr) begin
        e = idle_exp(); e.rv = 1; e.rd = 16'h0000; e.tag = "R9";
        q.push_back(e);
      end
    end else if (!wr) begin
      for (int i = 0; i < RD; i++) begin
        e = idle_exp(); e.ce = 0; e.oe = 0; e.lb = !be[0]; e.ub = !be[1];
        e.rdy = 0; e.a = a; e.tag = "R3"; q.push_back(e);
      end
      for (int i = 0; i < HZ; i++) begin
        e = idle_exp(); e.rdy = 0; e.tag = "R6";
        if (i == 0) begin e.rv = 1; e.rd = ref_rd(a, be); e.tag = "R4"; end
        q.push_back(e);
      end
    end else begin
      for (int i = 0; i < WR; i++) begin
        e = idle_exp(); e.ce = 0; e.we = 0; e.lb = !be[0]; e.ub = !be[1];
        e.doe = be; e.rdy = 0; e.a = a; e.d = wd; e.tag = "R5"; q.push_back(e);
      end
      e = idle_exp(); e.rdy = 0; e.tag = "R7"; q.push_back(e);
      w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
      if (be[0]) w[7:0] = wd[7:0];
      if (be[1]) w[15:8] = wd[15:8];
      ref_mem[int'(a)] = w;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(input bit wr, input logic [19:0] a, input logic [1:0] be,
                    input logic [15:0] wd);
    issue(wr, a, be, wd);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({req_ready, rsp_valid, mem_ce1_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}
          == 9'b1_0_11111_00, "R1", "reset pins",
          32'({req_ready, rsp_valid, mem_ce1_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}),
          32'h17C);
    rst_n = 1;
    repeat (2) @(negedge clk);

    op(1, 20'h00010, 2'b11, 16'h1234);   // R5 word write
    op(0, 20'h00010, 2'b11, 16'h0000);   // R3 R4 word read
    op(1, 20'h00010, 2'b01, 16'h99CD);   // low byte write
    op(0, 20'h00010, 2'b10, 16'h0000);   // R4 upper only
    op(0, 20'h00010, 2'b01, 16'h0000);   // R4 lower only
    op(1, 20'hFFFFF, 2'b10, 16'hBEEF);   // upper byte at top address
    op(1, 20'h00010, 2'b00, 16'hFFFF);   // R9 zero-lane write
    issue(0, 20'h00010, 2'b00, 16'h0000); // R9 zero-lane read
    issue(0, 20'h00010, 2'b11, 16'h0000); // back to back with response cycle
    settle();
    op(0, 20'hFFFFF, 2'b11, 16'h0000);
    for (int i = 0; i < 8; i++)
      op(1, 20'(i * 20'h1F3 + 5), 2'(i % 3 + 1), 16'(i * 16'h1357 + 16'h0A0B));
    for (int i = 0; i < 8; i++)
      op(0, 20'(i * 20'h1F3 + 5), 2'b11, 16'h0000);
    op(1, 20'h00020, 2'b11, 16'hC3C3);
    op(0, 20'h00020, 2'b11, 16'h0000);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule